// File: doc/BRIEF.md
# Interleaved-Thread Integer Lane

This block is one execution lane of a SIMT core. It is a fixed-latency integer datapath in which every stage can hold an instruction from a different thread. The issue logic sends one thread-instruction per clock, with its operands already read from the register file. Each instruction carries a warp tag, a thread index, an opcode and three operands. Every result leaves on a write-back port after the same number of cycles, with the same warp tag and thread index it came in with.

Threads that sit together in the pipeline are independent, so the lane has no forwarding paths, no hazard checks and no stall input. A warp holds the lane for four back-to-back issue slots, one for each of its threads, and all four share one context tag. With eight stages and four-slot warp turns, no more than three warp contexts are ever inside the lane at once. An issue slot with no valid instruction becomes a bubble, and that bubble leaves the lane with its valid flag low.

Top module: `simt_lane`

## Requirements
- R1: A synchronous active-high reset clears every stage. `wb_valid` is low while reset is held, and stays low afterwards until a newly issued instruction reaches the end of the lane. Instructions that were in flight when reset was applied never come out.
- R2: Latency is fixed at DEPTH = 8 clocks for every opcode. An instruction captured at rising edge N appears on the write-back port right after rising edge N+7.
- R3: Opcode 2'b00 (ADD) returns a + b modulo 2^32.
- R4: Opcode 2'b01 (MUL) returns the low 32 bits of a * b.
- R5: Opcode 2'b10 (MAD) returns the low 32 bits of a * b + c.
- R6: Opcode 2'b11 (MOV) returns operand a unchanged.
- R7: The lane accepts one instruction on every clock with no stall. Results leave one per clock, in issue order.
- R8: `wb_warp` and `wb_tid` equal the warp tag and thread index given at issue.
- R9: A cycle with `iss_valid` low produces exactly one bubble at the output, DEPTH clocks later. Opcode and operand values present in such a cycle have no effect on any output.
- R10: A warp issues as a group of four consecutive slots with thread indices 0, 1, 2, 3 and one warp tag. Bubbles are allowed only between groups. The output keeps each group contiguous and in order.
- R11: The number of instructions inside the lane never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Issue slot holds an instruction |
| iss_warp | input | WARP_W (5) | Warp context tag |
| iss_tid | input | 2 | Thread index within the warp's four-slot turn |
| iss_op | input | 2 | Opcode: 00 ADD, 01 MUL, 10 MAD, 11 MOV |
| iss_a | input | DATA_W (32) | Operand a |
| iss_b | input | DATA_W (32) | Operand b |
| iss_c | input | DATA_W (32) | Operand c (used by MAD) |
| wb_valid | output | 1 | Write-back slot holds a result |
| wb_warp | output | WARP_W (5) | Warp tag of the result |
| wb_tid | output | 2 | Thread index of the result |
| wb_data | output | DATA_W (32) | Result value |

## Verification
The scoreboard stamps every item with the exact cycle it is due. A stage that drops or duplicates its valid flag therefore shows up on the due cycle, as a missing or unexpected write-back. A wrong opcode decode or a corrupted carried tag shows up on the very cycle that instruction leaves. A lost reset clear lets stale results appear within DEPTH clocks of reset release. A chain one stage too long or too short shifts every result by a cycle, so the first issued instruction already exposes it. Operand patterns include wrap-around sums and large products, so truncation faults appear in the low 32 bits.

// File: rtl/simt_lane.sv
module simt_lane #(
  parameter int DATA_W = 32,
  parameter int WARP_W = 5,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [WARP_W-1:0] iss_warp,
  input  logic [1:0]        iss_tid,
  input  logic [1:0]        iss_op,
  input  logic [DATA_W-1:0] iss_a,
  input  logic [DATA_W-1:0] iss_b,
  input  logic [DATA_W-1:0] iss_c,
  output logic              wb_valid,
  output logic [WARP_W-1:0] wb_warp,
  output logic [1:0]        wb_tid,
  output logic [DATA_W-1:0] wb_data
);
  localparam int CNT_W = $clog2(DEPTH + 1) + 1;
  localparam logic [1:0] OP_ADD = 2'b00, OP_MUL = 2'b01, OP_MAD = 2'b10;

  logic [DEPTH-1:0]  v;
  logic [WARP_W-1:0] w   [DEPTH];
  logic [1:0]        t   [DEPTH];
  logic [DATA_W-1:0] r   [DEPTH];

  logic [1:0]        op0;
  logic [DATA_W-1:0] a0, b0, c0;
  logic [DATA_W-1:0] c1;
  logic              addc1;

  always_ff @(posedge clk) begin
    if (rst) v <= '0;
    else     v <= {v[DEPTH-2:0], iss_valid};
  end

  always_ff @(posedge clk) begin
    w[0] <= iss_warp;
    t[0] <= iss_tid;
    op0  <= iss_op;
    a0   <= iss_a;
    b0   <= iss_b;
    c0   <= iss_c;
    r[0] <= '0;
  end

  always_ff @(posedge clk) begin
    w[1]  <= w[0];
    t[1]  <= t[0];
    c1    <= c0;
    addc1 <= (op0 == OP_MAD);
    case (op0)
      OP_ADD:  r[1] <= a0 + b0;
      OP_MUL,
      OP_MAD:  r[1] <= a0 * b0;
      default: r[1] <= a0;
    endcase
  end

  always_ff @(posedge clk) begin
    w[2] <= w[1];
    t[2] <= t[1];
    r[2] <= addc1 ? r[1] + c1 : r[1];
  end

  for (genvar k = 3; k < DEPTH; k++) begin : g_delay
    always_ff @(posedge clk) begin
      w[k] <= w[k-1];
      t[k] <= t[k-1];
      r[k] <= r[k-1];
    end
  end

  assign wb_valid = v[DEPTH-1];
  assign wb_warp  = w[DEPTH-1];
  assign wb_tid   = t[DEPTH-1];
  assign wb_data  = r[DEPTH-1];

  logic [CNT_W-1:0] inflight, since_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight  <= '0;
      since_rst <= '0;
    end else begin
      inflight <= inflight + CNT_W'(iss_valid) - CNT_W'(wb_valid);
      if (since_rst < CNT_W'(DEPTH)) since_rst <= since_rst + 1'b1;
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk) rst |=> !wb_valid);

  p_no_early_output_r1: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CNT_W'(DEPTH)) |-> !wb_valid);

  p_inflight_bound_r11: assert property (@(posedge clk) disable iff (rst)
    inflight <= CNT_W'(DEPTH));

  p_issue_group_r10: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_tid != 2'd0) |-> ($past(iss_valid) &&
      iss_warp == $past(iss_warp) && iss_tid == $past(iss_tid) + 2'd1));

  p_wb_group_r10: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_tid != 2'd0) |-> ($past(wb_valid) &&
      wb_warp == $past(wb_warp) && wb_tid == $past(wb_tid) + 2'd1));

  p_group_completes_r7: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_tid != 2'd3) |=> wb_valid);
endmodule

// File: tb/simt_lane_test.sv
module simt_lane_test;
  localparam int DATA_W = 32, WARP_W = 5, DEPTH = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic iss_valid = 1'b0;
  logic [WARP_W-1:0] iss_warp = '0;
  logic [1:0] iss_tid = '0, iss_op = '0;
  logic [DATA_W-1:0] iss_a = '0, iss_b = '0, iss_c = '0;
  logic wb_valid;
  logic [WARP_W-1:0] wb_warp;
  logic [1:0] wb_tid;
  logic [DATA_W-1:0] wb_data;

  simt_lane #(.DATA_W(DATA_W), .WARP_W(WARP_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_warp(iss_warp),
    .iss_tid(iss_tid), .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b),
    .iss_c(iss_c), .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_tid(wb_tid),
    .wb_data(wb_data));

  always #2.5 clk = ~clk;

  typedef struct {
    int unsigned       due;
    logic [WARP_W-1:0] warp;
    logic [1:0]        tid;
    logic [DATA_W-1:0] data;
    string             req;
  } item_t;

  item_t q[$];
  int unsigned pcyc = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always @(posedge clk) pcyc <= pcyc + 1;

  function automatic logic [DATA_W-1:0] model(logic [1:0] op, logic [DATA_W-1:0] a,
                                              logic [DATA_W-1:0] b, logic [DATA_W-1:0] c);
    logic [63:0] p;
    p = 64'(a) * 64'(b);
    case (op)
      2'b00:   return a + b;
      2'b01:   return p[DATA_W-1:0];
      2'b10:   return p[DATA_W-1:0] + c;
      default: return a;
    endcase
  endfunction

  task automatic issue(input logic [WARP_W-1:0] wp, input logic [1:0] tid,
                       input logic [1:0] op, input logic [DATA_W-1:0] a,
                       input logic [DATA_W-1:0] b, input logic [DATA_W-1:0] c,
                       input string req);
    item_t it;
    @(posedge clk); #1;
    iss_valid = 1'b1; iss_warp = wp; iss_tid = tid; iss_op = op;
    iss_a = a; iss_b = b; iss_c = c;
    it.due = pcyc + DEPTH; it.warp = wp; it.tid = tid;
    it.data = model(op, a, b, c); it.req = req;
    q.push_back(it);
  endtask

  task automatic bubble(input logic [DATA_W-1:0] junk);
    @(posedge clk); #1;
    iss_valid = 1'b0; iss_warp = junk[WARP_W-1:0]; iss_tid = junk[1:0];
    iss_op = junk[3:2]; iss_a = junk; iss_b = ~junk; iss_c = junk ^ 32'h5a5a_5a5a;
  endtask

  task automatic warp4(input logic [WARP_W-1:0] wp, input logic [1:0] op,
                       input logic [DATA_W-1:0] seed, input string req);
    for (int i = 0; i < 4; i++)
      issue(wp, 2'(i), op, seed * (i + 3) + 32'h7fff_fff0, seed + 32'(i) * 32'h1001,
            seed ^ 32'(i * 77), req);
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (wb_valid) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R9: unexpected write-back warp=%0d tid=%0d data=%h, expected none",
                   wb_warp, wb_tid, wb_data);
        end else begin
          item_t e;
          e = q.pop_front();
          if (e.due != pcyc || wb_warp != e.warp || wb_tid != e.tid || wb_data != e.data) begin
            fails++;
            $display("FAIL %s/R2/R8: got cyc=%0d warp=%0d tid=%0d data=%h, expected cyc=%0d warp=%0d tid=%0d data=%h",
                     e.req, pcyc, wb_warp, wb_tid, wb_data, e.due, e.warp, e.tid, e.data);
          end
        end
      end else if (q.size() > 0 && q[0].due <= pcyc) begin
        checks++; fails++;
        $display("FAIL R2/R7: missing write-back, got valid=0, expected warp=%0d tid=%0d due cyc=%0d",
                 q[0].warp, q[0].tid, q[0].due);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      done = 1'b1; fails++; checks++;
      $display("FAIL watchdog: run hung, got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk_quiet(input string req);
    @(negedge clk);
    checks++;
    if (wb_valid !== 1'b0) begin
      fails++;
      $display("FAIL %s: got wb_valid=%b, expected 0", req, wb_valid);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    chk_quiet("R1");
    @(posedge clk); #1 rst = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) chk_quiet("R1");

    issue(5'd1, 2'd0, 2'b00, 32'd5, 32'd7, 32'd0, "R3");
    issue(5'd1, 2'd1, 2'b00, 32'hffff_fffe, 32'd5, 32'd0, "R3");
    issue(5'd1, 2'd2, 2'b01, 32'h0001_0003, 32'h0002_0005, 32'd0, "R4");
    issue(5'd1, 2'd3, 2'b10, 32'hdead_beef, 32'h1234_5678, 32'hffff_ffff, "R5");
    bubble(32'hffff_ffff);
    issue(5'd2, 2'd0, 2'b11, 32'hcafe_f00d, 32'd9, 32'd9, "R6");
    issue(5'd2, 2'd1, 2'b10, 32'd3, 32'd4, 32'd5, "R5");
    issue(5'd2, 2'd2, 2'b01, 32'hffff_ffff, 32'hffff_ffff, 32'd0, "R4");
    issue(5'd2, 2'd3, 2'b00, 32'd0, 32'd0, 32'd0, "R3");

    warp4(5'd3, 2'b10, 32'h0101_0101, "R10");
    warp4(5'd30, 2'b00, 32'h8000_0001, "R7");
    warp4(5'd17, 2'b01, 32'h1357_9bdf, "R8");
    for (int i = 0; i < 3; i++) bubble(32'h0f0f_0f0f * 32'(i + 1));
    warp4(5'd31, 2'b11, 32'h2468_ace0, "R9");
    bubble(32'h0);
    for (int k = 0; k < 40; k++) begin
      warp4(5'(k), 2'(k), 32'h9e37_79b9 * 32'(k + 1), "R7");
      if (k % 5 == 0) bubble(32'h3c3c_3c3c);
    end
    bubble(32'h0);
    repeat (DEPTH + 2) @(posedge clk);

    warp4(5'd9, 2'b10, 32'h7777_1111, "R1");
    @(posedge clk); #1 rst = 1'b1; iss_valid = 1'b0;
    @(posedge clk); #1;
    q.delete();
    @(posedge clk); #1 rst = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) chk_quiet("R1");

    warp4(5'd4, 2'b00, 32'h0000_00ff, "R2");
    bubble(32'h0);
    repeat (DEPTH + 3) @(posedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R7: got %0d results outstanding, expected 0", q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule